// File: doc/BRIEF.md
# Text-Mode Cell Renderer

This block converts a character/attribute screen buffer into a stream of 4-bit pixels for a raster display. An external timing generator supplies a horizontal pixel counter `hcnt` (0 to `H_TOTAL-1`, with visible pixels starting at 0), a line counter `vcnt` (0 to `V_TOTAL-1`, advancing when `hcnt` wraps) and a display-enable `vid_en`. The screen is a grid of `COLS` by `ROWS` cells. Each cell is `CELL_W` (9) pixels wide and `CELL_H` (14) lines tall. Each cell owns two consecutive bytes in the buffer: the character code at the even address, and its attribute at the odd address after it.

For each cell a fetch engine reads the character and the attribute through a synchronous buffer port. It then presents the code and the line-within-cell to a synchronous font port. The glyph row is fetched during the previous cell's display time, or during the last line's blanking for column 0, so it is ready when the cell starts. A 9-bit shift register serialises each glyph row. It holds the 8 font bits followed by one forced-off column. An attribute decoder turns each bit into foreground or background colour. A frame counter sets the blink phase.

The fetch engine is a state machine. **IDLE** moves to **CHAR** at the line trigger (`hcnt == H_TOTAL-CELL_W-1`) when the next line lies inside the text area. The sequence then runs **CHAR** (character address) → **ATTR** (attribute address, character captured) → **GLYPH** (attribute captured, font port addressed) → **LATCH** (glyph row captured) → **HOLD**. **HOLD** waits until the cell's ninth cycle ends. It then moves to **CHAR** for the next column, or to **TAIL** after the last column. **TAIL** hands the last cell to the shift register and returns to **IDLE**.

Top module: `txt_render`

## Requirements
- R1: While reset is asserted, and after its release until the first text pixel, `pix` is 0000.
- R2: For cell column c, cell row r, the character byte is read at address r*2*COLS + 2c. The attribute is read at the next address in the cycle directly after. One cycle later the character code read is on `font_code`. `font_row` carries y mod CELL_H.
- R3: Within a cell, pixel p (0 to 7) shows glyph bit 7-p. A set bit gives `pix` = {attribute bit 3 (intensity), attribute bits 2:0 (foreground R,G,B)}.
- R4: The ninth pixel column of every cell always shows the background colour.
- R5: A clear glyph bit gives `pix` = {0, attribute bits 6:4 (background R,G,B)}.
- R6: A frame counter advances once per frame start. When its bit BLINK_LOG2 is 1 and attribute bit 7 (blink) is set, the whole cell shows background colour. Otherwise blink has no effect.
- R7: Whenever `vid_en` was low for a pixel, that pixel's `pix` is 0000.
- R8: Pixels with x >= COLS*CELL_W or y >= ROWS*CELL_H show 0000 even with `vid_en` high.
- R9: The colour for the counter position presented in one clock appears on `pix` two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcnt | input | CNT_W | Horizontal pixel counter |
| vcnt | input | CNT_W | Line counter |
| vid_en | input | 1 | High inside the visible area |
| buf_addr | output | clog2(ROWS*COLS*2) | Screen buffer byte address |
| buf_rdata | input | 8 | Buffer data, one clock after address |
| font_code | output | 8 | Character code to the font port |
| font_row | output | clog2(CELL_H) | Line within the cell to the font port |
| font_rdata | input | 8 | Glyph row, one clock after address |
| pix | output | 4 | Pixel colour {I,R,G,B} |

## Verification
The assertions check the fetch order on every cycle: an odd attribute address always follows its even character address, and the CHAR→ATTR→GLYPH→LATCH→HOLD chain never skips a step. They also check that a pixel with `vid_en` low comes out black two clocks later, and that the ninth column never carries the intensity bit. The full pixel mapping can only be shown by the bench's sweeps, which compare every pixel of several frames against arithmetic expectations. That mapping covers the cell address, glyph bit order, the foreground/background colour split, the blink phase across frames and the blank margins.

// File: rtl/txtr_pkg.sv
package txtr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHAR,
        ST_ATTR,
        ST_GLYPH,
        ST_LATCH,
        ST_HOLD,
        ST_TAIL
    } fetch_st_e;

    typedef struct packed {
        logic       blink;
        logic [2:0] bg;
        logic       intens;
        logic [2:0] fg;
    } attr_t;

    localparam int GLYPH_W = 8;

endpackage

// File: rtl/txtr_line_track.sv
module txtr_line_track #(
    parameter int CNT_W      = 10,
    parameter int H_TOTAL    = 800,
    parameter int V_TOTAL    = 521,
    parameter int CELL_W     = 9,
    parameter int CELL_H     = 14,
    parameter int ROWS       = 34,
    parameter int BLINK_LOG2 = 4,
    parameter int RW         = $clog2(ROWS + 1),
    parameter int SW         = $clog2(CELL_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    output logic             tick,
    output logic             nx_ok,
    output logic [RW-1:0]    row_q,
    output logic [SW-1:0]    scan_q,
    output logic             blink
);
    localparam int TRIG  = H_TOTAL - CELL_W - 1;
    localparam int FRM_W = BLINK_LOG2 + 1;

    logic [RW-1:0]    row_nx;
    logic [SW-1:0]    scan_nx;
    logic [FRM_W-1:0] frm_q, frm_nx;

    assign tick  = (hcnt == CNT_W'(TRIG));
    assign nx_ok = (row_nx != RW'(ROWS));
    assign blink = frm_q[BLINK_LOG2];

    always_comb begin
        row_nx  = row_q;
        scan_nx = scan_q;
        frm_nx  = frm_q;
        if (tick) begin
            if (vcnt == CNT_W'(V_TOTAL - 1)) begin
                row_nx  = '0;
                scan_nx = '0;
                frm_nx  = frm_q + 1'b1;
            end else if (row_q != RW'(ROWS)) begin
                if (scan_q == SW'(CELL_H - 1)) begin
                    scan_nx = '0;
                    row_nx  = row_q + 1'b1;
                end else begin
                    scan_nx = scan_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= RW'(ROWS);
            scan_q <= '0;
            frm_q  <= '0;
        end else begin
            row_q  <= row_nx;
            scan_q <= scan_nx;
            frm_q  <= frm_nx;
        end
    end

endmodule

// File: rtl/txtr_fetch_fsm.sv
module txtr_fetch_fsm
    import txtr_pkg::*;
#(
    parameter int CELL_W = 9,
    parameter int COLS   = 40,
    parameter int ROWS   = 34,
    parameter int RW     = $clog2(ROWS + 1),
    parameter int AW     = $clog2(ROWS * COLS * 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               nx_ok,
    input  logic [RW-1:0]      row_q,
    input  logic [7:0]         buf_rdata,
    input  logic [7:0]         font_rdata,
    output logic [AW-1:0]      buf_addr,
    output logic [7:0]         font_code,
    output fetch_st_e          st,
    output logic               load,
    output logic [GLYPH_W-1:0] glyph_q,
    output attr_t              attr_q
);
    localparam int ROW_BYTES = 2 * COLS;
    localparam int COL_W     = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int K_W       = $clog2(CELL_W);

    fetch_st_e        st_nx;
    logic [COL_W-1:0] fcol;
    logic [K_W-1:0]   kcnt;
    logic [7:0]       char_q;
    logic [AW-1:0]    base;
    logic             cell_end;
    logic             last_col;

    assign cell_end = (kcnt == K_W'(CELL_W - 1));
    assign last_col = (fcol == COL_W'(COLS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (tick && nx_ok) st_nx = ST_CHAR;
            ST_CHAR:  st_nx = ST_ATTR;
            ST_ATTR:  st_nx = ST_GLYPH;
            ST_GLYPH: st_nx = ST_LATCH;
            ST_LATCH: st_nx = ST_HOLD;
            ST_HOLD:  if (cell_end) st_nx = last_col ? ST_TAIL : ST_CHAR;
            ST_TAIL:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // window counters and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcol    <= '0;
            kcnt    <= '0;
            char_q  <= '0;
            attr_q  <= '0;
            glyph_q <= '0;
        end else begin
            kcnt <= (st_nx == ST_CHAR) ? '0 : kcnt + 1'b1;
            if (st == ST_IDLE && st_nx == ST_CHAR)
                fcol <= '0;
            else if (st == ST_HOLD && st_nx == ST_CHAR)
                fcol <= fcol + 1'b1;
            if (st == ST_ATTR)  char_q  <= buf_rdata;
            if (st == ST_GLYPH) attr_q  <= attr_t'(buf_rdata);
            if (st == ST_LATCH) glyph_q <= font_rdata;
        end
    end

    // outputs
    always_comb begin
        base      = AW'(row_q) * AW'(ROW_BYTES) + (AW'(fcol) << 1);
        buf_addr  = base + AW'(st == ST_ATTR);
        font_code = char_q;
        load      = (st == ST_CHAR && fcol != '0) || (st == ST_TAIL);
    end

endmodule

// File: rtl/txtr_serializer.sv
module txtr_serializer
    import txtr_pkg::*;
#(
    parameter int CELL_W = 9,
    parameter int DPH_W  = $clog2(CELL_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GLYPH_W-1:0] glyph,
    input  attr_t              attr,
    input  logic               vid_en,
    input  logic               blink,
    output logic [3:0]         pix,
    output logic               txt_on,
    output logic [DPH_W-1:0]   txt_dph
);
    logic [CELL_W-1:0] sr;
    attr_t             at_d;
    logic              ven_d;
    logic              fg_on;

    // stage 1: shift register follows the pixel counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            at_d    <= '0;
            txt_on  <= 1'b0;
            txt_dph <= '0;
            ven_d   <= 1'b0;
        end else begin
            ven_d <= vid_en;
            if (load) begin
                sr      <= {glyph, {(CELL_W - GLYPH_W){1'b0}}};
                at_d    <= attr;
                txt_on  <= 1'b1;
                txt_dph <= '0;
            end else begin
                sr      <= {sr[CELL_W-2:0], 1'b0};
                txt_dph <= (txt_dph == DPH_W'(CELL_W - 1)) ? '0 : txt_dph + 1'b1;
                if (txt_dph == DPH_W'(CELL_W - 1)) txt_on <= 1'b0;
            end
        end
    end

    assign fg_on = sr[CELL_W-1] && !(at_d.blink && blink);

    // stage 2: colour decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pix <= 4'h0;
        else if (!ven_d || !txt_on) pix <= 4'h0;
        else if (fg_on)            pix <= {at_d.intens, at_d.fg};
        else                       pix <= {1'b0, at_d.bg};
    end

endmodule

// File: rtl/txt_render.sv
module txt_render
    import txtr_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int H_TOTAL    = 800,
    parameter int V_TOTAL    = 521,
    parameter int CELL_W     = 9,
    parameter int CELL_H     = 14,
    parameter int COLS       = 40,
    parameter int ROWS       = 34,
    parameter int BLINK_LOG2 = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [CNT_W-1:0]                   hcnt,
    input  logic [CNT_W-1:0]                   vcnt,
    input  logic                               vid_en,
    output logic [$clog2(ROWS*COLS*2)-1:0]     buf_addr,
    input  logic [7:0]                         buf_rdata,
    output logic [7:0]                         font_code,
    output logic [$clog2(CELL_H)-1:0]          font_row,
    input  logic [7:0]                         font_rdata,
    output logic [3:0]                         pix
);
    localparam int AW    = $clog2(ROWS * COLS * 2);
    localparam int RW    = $clog2(ROWS + 1);
    localparam int SW    = $clog2(CELL_H);
    localparam int DPH_W = $clog2(CELL_W);

    logic               tick;
    logic               nx_ok;
    logic [RW-1:0]      row_q;
    logic [SW-1:0]      scan_q;
    logic               blink;
    fetch_st_e          st;
    logic               load;
    logic [GLYPH_W-1:0] glyph_q;
    attr_t              attr_q;
    logic               txt_on;
    logic [DPH_W-1:0]   txt_dph;

    txtr_line_track #(
        .CNT_W(CNT_W), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
        .CELL_W(CELL_W), .CELL_H(CELL_H), .ROWS(ROWS),
        .BLINK_LOG2(BLINK_LOG2), .RW(RW), .SW(SW)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
        .tick(tick), .nx_ok(nx_ok), .row_q(row_q), .scan_q(scan_q),
        .blink(blink)
    );

    txtr_fetch_fsm #(
        .CELL_W(CELL_W), .COLS(COLS), .ROWS(ROWS), .RW(RW), .AW(AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nx_ok(nx_ok),
        .row_q(row_q), .buf_rdata(buf_rdata), .font_rdata(font_rdata),
        .buf_addr(buf_addr), .font_code(font_code), .st(st),
        .load(load), .glyph_q(glyph_q), .attr_q(attr_q)
    );

    txtr_serializer #(
        .CELL_W(CELL_W), .DPH_W(DPH_W)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .load(load), .glyph(glyph_q),
        .attr(attr_q), .vid_en(vid_en), .blink(blink), .pix(pix),
        .txt_on(txt_on), .txt_dph(txt_dph)
    );

    assign font_row = scan_q;

endmodule

// File: rtl/txt_render_chk.sv
module txt_render_chk
    import txtr_pkg::*;
#(
    parameter int CELL_W = 9,
    parameter int AW     = 12,
    parameter int DPH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vid_en,
    input logic [3:0]       pix,
    input logic [AW-1:0]    buf_addr,
    input fetch_st_e        st,
    input logic             txt_on,
    input logic [DPH_W-1:0] txt_dph
);
    // R2: attribute address directly follows its character address
    a_r2_attr_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        buf_addr[0] |-> buf_addr == $past(buf_addr) + AW'(1));

    // R2: fetch chain order
    a_r2_char_to_attr: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_CHAR |=> st == ST_ATTR);
    a_r2_attr_to_glyph: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ATTR |=> st == ST_GLYPH);
    a_r2_glyph_to_latch: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_GLYPH |=> st == ST_LATCH);
    a_r2_latch_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_LATCH |=> st == ST_HOLD);

    // R7: disabled pixel is black two clocks later
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |-> ##2 pix == 4'h0);

    // R4: ninth column never carries intensity
    a_r4_ninth_bg: assert property (@(posedge clk) disable iff (!rst_n)
        (txt_on && txt_dph == DPH_W'(CELL_W - 1)) |=> pix[3] == 1'b0);

endmodule

bind txt_render txt_render_chk #(
    .CELL_W(CELL_W), .AW(AW), .DPH_W(DPH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .pix(pix),
    .buf_addr(buf_addr), .st(st), .txt_on(txt_on), .txt_dph(txt_dph)
);

// File: tb/tb_txt_render.sv
`timescale 1ns/1ps
module tb_txt_render;
    localparam int CNT_W = 6, H_TOTAL = 40, V_TOTAL = 32;
    localparam int CW = 9, CH = 14, COLS = 3, ROWS = 2, BLOG = 1;
    localparam int ACT_W = 30, ACT_H = 30, NF = 6;
    localparam int AW = $clog2(ROWS*COLS*2);
    localparam int SW = $clog2(CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] hcnt = '0, vcnt = '0;
    logic vid_en = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_rdata, font_code, font_rdata;
    logic [SW-1:0] font_row;
    logic [3:0] pix;

    int checks = 0, errors = 0, nframe = 0;
    logic [7:0] mem [16];

    always #4 clk = ~clk;

    txt_render #(.CNT_W(CNT_W), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
        .CELL_W(CW), .CELL_H(CH), .COLS(COLS), .ROWS(ROWS),
        .BLINK_LOG2(BLOG)) dut (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .vid_en(vid_en),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .font_code(font_code),
        .font_row(font_row), .font_rdata(font_rdata), .pix(pix));

    function automatic logic [7:0] glyph(int code, int row);
        int v = code * 13 + row * 7 + (code >> 3);
        return 8'(v) ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        buf_rdata  <= mem[buf_addr];
        font_rdata <= glyph(int'(font_code), int'(font_row));
    end

    task automatic fill(int pat);
        for (int i = 0; i < ROWS*COLS; i++) begin
            logic [7:0] a;
            mem[2*i]   = 8'(i * 29 + pat * 71 + 5);
            a          = 8'((i * 53 + pat * 97 + 11) ^ (pat << 5));
            mem[2*i+1] = {i[0] ^ pat[0], a[6:0]};
        end
    endtask

    task automatic check(bit ok, string tag, int act, int exp, int x, int y);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s x=%0d y=%0d actual %0h expected %0h", tag, x, y, act, exp);
        end
    endtask

    // expected pixel for a counter position (R3..R8)
    task automatic expect_pix(int x, int y, bit en, output logic [3:0] e, output string tag);
        if (!en) begin e = 4'h0; tag = "R7"; end
        else if (x >= COLS*CW || y >= ROWS*CH) begin e = 4'h0; tag = "R8"; end
        else begin
            int c = x / CW, r = y / CH, s = y % CH, p = x % CW;
            logic [7:0] ch = mem[(r*COLS + c)*2];
            logic [7:0] at = mem[(r*COLS + c)*2 + 1];
            logic [7:0] g = glyph(int'(ch), s);
            bit b = (p < 8) ? g[7-p] : 1'b0;
            bit hid = at[7] && ((nframe >> BLOG) & 1) == 1;
            if (b && !hid) begin e = {at[3], at[2:0]}; tag = "R3 R2"; end
            else begin
                e = {1'b0, at[6:4]};
                tag = (p == 8) ? "R4" : ((b && hid) ? "R6" : "R5");
            end
        end
    endtask

    logic [3:0] e1, e2;
    string t1, t2;
    int x1, y1, x2, y2, nvalid = 0;
    logic [AW-1:0] prev_addr;
    bit pend = 0;
    logic [7:0] pend_code;

    task automatic step(int x, int y, bit en);
        logic [3:0] e;
        string t;
        @(negedge clk);
        if (nvalid >= 2) check(pix == e2, {t2, " R9"}, pix, e2, x2, y2);
        if (pend) begin
            check(font_code == pend_code, "R2 code", font_code, pend_code, x, y);
            pend = 0;
        end
        if (buf_addr[0]) begin
            check(prev_addr == buf_addr - 1'b1, "R2 addr", prev_addr, buf_addr - 1'b1, x, y);
            pend = 1;
            pend_code = mem[buf_addr - 1'b1];
        end
        prev_addr = buf_addr;
        if (x == 0 && y == 0) nframe++;
        expect_pix(x, y, en, e, t);
        e2 = e1; t2 = t1; x2 = x1; y2 = y1;
        e1 = e;  t1 = t;  x1 = x;  y1 = y;
        nvalid++;
        hcnt = CNT_W'(x); vcnt = CNT_W'(y); vid_en = en;
    endtask

    bit done = 0;
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        fill(0);
        hcnt = '0; vcnt = CNT_W'(V_TOTAL - 1);
        repeat (3) @(negedge clk);
        check(pix == 4'h0, "R1 in reset", pix, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix == 4'h0, "R1 after release", pix, 0, 0, 0);
        for (int x = 1; x < H_TOTAL; x++) step(x, V_TOTAL - 1, 1'b0);
        check(pix == 4'h0, "R1 before text", pix, 0, 0, 0);
        for (int f = 1; f <= NF; f++) begin
            for (int y = 0; y < V_TOTAL; y++)
                for (int x = 0; x < H_TOTAL; x++) begin
                    bit en = (x < ACT_W) && (y < ACT_H);
                    if (f == 4 && (x + y) % 5 == 0) en = 1'b0;
                    if (x == 0 && y == ACT_H) fill(f);
                    step(x, y, en);
                end
        end
        step(0, 0, 1'b0);
        step(1, 0, 1'b0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule